// File: doc/BRIEF.md
# Overload Shutdown and Retry Supervisor

This block sits beside the pre-charge sequencer of an AC-DC front end. It watches an over-current flag from a comparator on the bulk capacitor's output current, after that flag has been synchronized into the clock domain. When the flag stays high for long enough while the supply is running, the block opens both the load switch and the pre-charge switch in the same cycle. It also withdraws its permission for power-good.

Two responses can be selected. In latched mode the block holds the fault until a user clear arrives. In retry mode it waits a programmable number of cycles and then pulses a restart request, so that the sequencer runs the full pre-charge again. It retries up to a programmable number of times. When that budget is used up, the next overload latches the fault as in latched mode. The attempt count returns to zero after a user clear, or after a programmable stretch of running with no overload.

Top module: `ovl_guard`

## Requirements
- R1: An overload is recognized only when `run_i` is high and `ovl_flag_i` has been high on at least 2 consecutive rising edges and is still high. A single-edge pulse, or any flag activity while `run_i` is low, causes no kill.
- R2: `kill_o` rises in the same cycle in which the overload is recognized, before any register has changed. It stays high in every state other than normal monitoring.
- R3: `pg_ok_o` is low whenever `ovl_flag_i` is high or `kill_o` is high. It is high while monitoring with the flag low.
- R4: With `cfg_retry_i`=0, a recognized overload enters the latched fault: `fault_o`=1 and `kill_o`=1 until `user_clr_i`, and `tries_o` is unchanged.
- R5: With `cfg_retry_i`=1 and `tries_o` < `cfg_max_tries_i`, a recognized overload increments `tries_o`. `restart_o` then pulses high for exactly one cycle, `cfg_wait_i`+2 cycles after the cycle of recognition. Monitoring resumes in the following cycle.
- R6: With `cfg_retry_i`=1 and `tries_o` = `cfg_max_tries_i` (including a budget of 0), a recognized overload enters the latched fault.
- R7: `user_clr_i` high in the latched fault returns the block to monitoring on the next edge, with `fault_o`=0, `kill_o`=0 and `tries_o`=0.
- R8: While monitoring, `tries_o` returns to 0 once the block has run with the flag low for `cfg_clean_i` consecutive cycles. A shorter quiet run leaves it unchanged.
- R9: After reset, `kill_o`, `restart_o`, `fault_o` and `tries_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovl_flag_i | input | 1 | Synchronized over-current comparator flag |
| run_i | input | 1 | Sequencer reports the supply as running |
| cfg_retry_i | input | 1 | 0 = latched shutdown, 1 = bounded retries |
| cfg_max_tries_i | input | CNT_W | Retry budget |
| cfg_wait_i | input | TMR_W | Wait before a restart request, in cycles |
| cfg_clean_i | input | TMR_W | Fault-free cycles that reset the attempt count |
| user_clr_i | input | 1 | User clear of the latched fault and attempt count |
| kill_o | output | 1 | Forces load and pre-charge switches off |
| restart_o | output | 1 | One-cycle request to rerun pre-charge |
| fault_o | output | 1 | Latched fault state |
| tries_o | output | CNT_W | Restart attempts used |
| pg_ok_o | output | 1 | Permission for power-good |

## Verification
The assertions assume that the configuration inputs stay steady while an overload is being handled. They also assume that the flag arrives already synchronized, so that it changes only away from the active edge. The bench changes the configuration only in monitoring or in the latched state, and drives every input at the falling edge. It sweeps the retry budget from 0 to 3 against wait values from 0 to 2. It also drives short glitches, flag activity with `run_i` low, and quiet runs on either side of the clean period.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef enum logic [1:0] {
    ST_MON  = 2'd0,
    ST_WAIT = 2'd1,
    ST_REQ  = 2'd2,
    ST_LOCK = 2'd3
  } sup_st_e;
endpackage

// File: rtl/ovl_qualify.sv
module ovl_qualify #(
  parameter int QUAL_CYC = 2,
  localparam int QW = $clog2(QUAL_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic flag_i,
  output logic hit_o
);
  logic [QW-1:0] hcnt_q, hcnt_d;

  always_comb begin
    hcnt_d = hcnt_q;
    if (!arm_i || !flag_i) begin
      hcnt_d = '0;
    end else if (hcnt_q < QW'(QUAL_CYC)) begin
      hcnt_d = hcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hcnt_q <= '0;
    else        hcnt_q <= hcnt_d;
  end

  assign hit_o = arm_i && flag_i && (hcnt_q >= QW'(QUAL_CYC));

  AST_HIT_NEEDS_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> $past(flag_i) && $past(arm_i)); // R1
endmodule

// File: rtl/ovl_timer.sv
module ovl_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [TMR_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             zero_o
);
  logic [TMR_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                    cnt_d = load_val_i;
    else if (dec_i && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  AST_WAIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R5
endmodule

// File: rtl/ovl_clean.sv
module ovl_clean #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [TMR_W-1:0] limit_i,
  output logic             done_o
);
  logic [TMR_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i)              cnt_d = '0;
    else if (cnt_q != '1)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done_o = en_i && (cnt_q >= limit_i);

  AST_CLEAN_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> cnt_q == '0); // R8
endmodule

// File: rtl/ovl_fsm.sv
module ovl_fsm
  import ovl_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_i,
  input  logic             retry_i,
  input  logic [CNT_W-1:0] max_i,
  input  logic             clr_i,
  input  logic             clean_i,
  input  logic             wait_zero_i,
  output sup_st_e          st_o,
  output logic             wait_load_o,
  output logic [CNT_W-1:0] tries_o
);
  sup_st_e          st_q, st_d;
  logic [CNT_W-1:0] tries_q, tries_d;

  always_comb begin
    st_d        = st_q;
    tries_d     = tries_q;
    wait_load_o = 1'b0;
    unique case (st_q)
      ST_MON: begin
        if (hit_i) begin
          if (retry_i && tries_q < max_i) begin
            st_d        = ST_WAIT;
            tries_d     = tries_q + 1'b1;
            wait_load_o = 1'b1;
          end else begin
            st_d = ST_LOCK;
          end
        end else if (clr_i || clean_i) begin
          tries_d = '0;
        end
      end
      ST_WAIT: if (wait_zero_i) st_d = ST_REQ;
      ST_REQ:  st_d = ST_MON;
      ST_LOCK: begin
        if (clr_i) begin
          st_d    = ST_MON;
          tries_d = '0;
        end
      end
      default: st_d = ST_LOCK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_MON;
      tries_q <= '0;
    end else begin
      st_q    <= st_d;
      tries_q <= tries_d;
    end
  end

  assign st_o    = st_q;
  assign tries_o = tries_q;

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOCK && !clr_i) |=> st_q == ST_LOCK); // R4
  AST_BUDGET_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_MON && hit_i && tries_q >= max_i) |=> st_q == ST_LOCK); // R6
  AST_TRY_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_MON && hit_i && retry_i && tries_q < max_i)
      |=> tries_q == $past(tries_q) + 1'b1); // R5
  AST_CLEAR_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOCK && clr_i) |=> (st_q == ST_MON && tries_q == '0)); // R7
endmodule

// File: rtl/ovl_guard.sv
module ovl_guard
  import ovl_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int TMR_W    = 16,
  parameter int QUAL_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ovl_flag_i,
  input  logic             run_i,
  input  logic             cfg_retry_i,
  input  logic [CNT_W-1:0] cfg_max_tries_i,
  input  logic [TMR_W-1:0] cfg_wait_i,
  input  logic [TMR_W-1:0] cfg_clean_i,
  input  logic             user_clr_i,
  output logic             kill_o,
  output logic             restart_o,
  output logic             fault_o,
  output logic [CNT_W-1:0] tries_o,
  output logic             pg_ok_o
);
  sup_st_e st;
  logic    in_mon, hit, wait_load, wait_zero, clean_done;

  assign in_mon = (st == ST_MON);

  ovl_qualify #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk(clk), .rst_n(rst_n), .arm_i(run_i && in_mon),
    .flag_i(ovl_flag_i), .hit_o(hit)
  );

  ovl_timer #(.TMR_W(TMR_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .load_i(wait_load), .load_val_i(cfg_wait_i),
    .dec_i(st == ST_WAIT), .zero_o(wait_zero)
  );

  ovl_clean #(.TMR_W(TMR_W)) u_clean (
    .clk(clk), .rst_n(rst_n), .en_i(in_mon && run_i && !ovl_flag_i),
    .limit_i(cfg_clean_i), .done_o(clean_done)
  );

  ovl_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .retry_i(cfg_retry_i),
    .max_i(cfg_max_tries_i), .clr_i(user_clr_i), .clean_i(clean_done),
    .wait_zero_i(wait_zero), .st_o(st), .wait_load_o(wait_load),
    .tries_o(tries_o)
  );

  assign kill_o    = hit || !in_mon;
  assign restart_o = (st == ST_REQ);
  assign fault_o   = (st == ST_LOCK);
  assign pg_ok_o   = in_mon && !ovl_flag_i;

  AST_KILL_AT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> kill_o && !pg_ok_o); // R2
  AST_PG_WITH_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    kill_o |-> !pg_ok_o); // R3
  AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> !restart_o && !kill_o); // R5
endmodule

// File: tb/tb_ovl_guard.sv
`timescale 1ns/1ps
module tb_ovl_guard;
  localparam int CNT_W = 4;
  localparam int TMR_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ovl_flag_i = 1'b0, run_i = 1'b1, cfg_retry_i = 1'b1;
  logic [CNT_W-1:0] cfg_max_tries_i = '0;
  logic [TMR_W-1:0] cfg_wait_i = '0;
  logic [TMR_W-1:0] cfg_clean_i = 16'd20;
  logic             user_clr_i = 1'b0;
  logic             kill_o, restart_o, fault_o, pg_ok_o;
  logic [CNT_W-1:0] tries_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ovl_guard #(.CNT_W(CNT_W), .TMR_W(TMR_W), .QUAL_CYC(2)) dut (
    .clk(clk), .rst_n(rst_n), .ovl_flag_i(ovl_flag_i), .run_i(run_i),
    .cfg_retry_i(cfg_retry_i), .cfg_max_tries_i(cfg_max_tries_i),
    .cfg_wait_i(cfg_wait_i), .cfg_clean_i(cfg_clean_i), .user_clr_i(user_clr_i),
    .kill_o(kill_o), .restart_o(restart_o), .fault_o(fault_o),
    .tries_o(tries_o), .pg_ok_o(pg_ok_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_pulse();
    @(negedge clk) user_clr_i = 1'b1;
    @(negedge clk) user_clr_i = 1'b0;
  endtask

  // Flag held high across three edges; checks each step of the response.
  task automatic overload(input bit exp_lock, input int exp_tries, input int w);
    int n;
    @(negedge clk) ovl_flag_i = 1'b1;
    @(negedge clk);
    check("R1 one edge high, no kill", int'(kill_o), 0);
    check("R3 pg low while flag high", int'(pg_ok_o), 0);
    @(negedge clk);
    check("R2 kill in recognition cycle", int'(kill_o), 1);
    @(negedge clk) ovl_flag_i = 1'b0;
    check("R5 R6 tries after overload", int'(tries_o), exp_tries);
    if (exp_lock) begin
      check("R4 R6 fault latched", int'(fault_o), 1);
      check("R4 kill held in fault", int'(kill_o), 1);
      check("R3 pg low in fault", int'(pg_ok_o), 0);
    end else begin
      check("R4 no fault on retry", int'(fault_o), 0);
      n = 0;
      while (!restart_o && n < 40) begin
        @(negedge clk);
        n++;
      end
      check("R5 restart delay", n, w + 1);
      check("R2 kill during restart cycle", int'(kill_o), 1);
      @(negedge clk);
      check("R5 restart is one cycle", int'(restart_o), 0);
      check("R5 monitoring resumed", int'(kill_o), 0);
      check("R3 pg back", int'(pg_ok_o), 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 kill", int'(kill_o), 0);
    check("R9 restart", int'(restart_o), 0);
    check("R9 fault", int'(fault_o), 0);
    check("R9 tries", int'(tries_o), 0);
    check("R3 pg after reset", int'(pg_ok_o), 1);

    // R1 single-edge glitches never kill
    for (int g = 0; g < 4; g++) begin
      @(negedge clk) ovl_flag_i = 1'b1;
      @(negedge clk) ovl_flag_i = 1'b0;
      check("R1 glitch kill", int'(kill_o), 0);
      @(negedge clk);
      check("R1 glitch kill later", int'(kill_o), 0);
    end
    // R1 flag ignored while not running
    run_i = 1'b0;
    @(negedge clk) ovl_flag_i = 1'b1;
    repeat (5) begin
      @(negedge clk);
      check("R1 idle flag ignored", int'(kill_o), 0);
    end
    ovl_flag_i = 1'b0;
    run_i = 1'b1;
    @(negedge clk);
    check("R1 no fault when idle", int'(fault_o), 0);

    // Sweep of retry budget and wait
    cfg_retry_i = 1'b1;
    for (int m = 0; m < 4; m++) begin
      for (int w = 0; w < 3; w++) begin
        cfg_max_tries_i = CNT_W'(m);
        cfg_wait_i = TMR_W'(w);
        clear_pulse();
        check("R7 clear in monitor", int'(tries_o), 0);
        for (int k = 0; k <= m; k++) overload(k == m, (k == m) ? m : k + 1, w);
        repeat (3) @(negedge clk);
        check("R4 fault persists", int'(fault_o), 1);
        clear_pulse();
        check("R7 fault cleared", int'(fault_o), 0);
        check("R7 kill released", int'(kill_o), 0);
        check("R7 tries cleared", int'(tries_o), 0);
      end
    end

    // Latched mode
    cfg_retry_i = 1'b0;
    cfg_max_tries_i = 4'd3;
    overload(1'b1, 0, 0);
    repeat (6) @(negedge clk);
    check("R4 latched without clear", int'(fault_o), 1);
    check("R4 no restart when latched", int'(restart_o), 0);
    clear_pulse();
    check("R7 latched mode cleared", int'(fault_o), 0);

    // Clean period resets attempt count
    cfg_retry_i = 1'b1;
    cfg_wait_i = 16'd1;
    cfg_clean_i = 16'd20;
    overload(1'b0, 1, 1);
    overload(1'b0, 2, 1);
    repeat (10) @(negedge clk);
    check("R8 short quiet keeps tries", int'(tries_o), 2);
    repeat (15) @(negedge clk);
    check("R8 quiet period clears tries", int'(tries_o), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule